// File: doc/BRIEF.md
# Scheduled Start/Stop Gate Controller

This block decides when a cyclic egress schedule engine may run. Software arms it by writing a command word with a start request. The engine is then released at the first clock on which a free-running time-of-day counter reaches a programmed 64-bit start time. A stop request halts the engine at any point. The time-of-day counter is an input, and the schedule engine it controls sits outside this block.

The start time is loaded as two 32-bit words. The controller moves through three states: disabled, armed (start requested, time not yet reached) and running. Software reads the state back through a status word. An input selects whether the schedule is driven from the time-of-day source. When it is not, the running and stopped status bits both read as zero and start requests are refused.

Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: a command write takes effect on the clock edge where `cmd_wr` is sampled high.

Top module: `sgc_gate_ctrl`

## Requirements
- R1: After reset the controller is disabled. `engine_run` is 0, `engine_start` is 0, `cmd_err` is 0, and `cmd_rdata` reads 0x2000_0000 (only the stopped bit, bit 29) while `use_tod` is 1.
- R2: A command write has an effect only when bit 31 (valid) of `cmd_wdata` is 1. A write with bit 31 clear leaves the state and `cmd_err` unchanged.
- R3: A valid write with bit 30 (start) = 1 and bit 29 (stop) = 0, made while the controller is disabled and `use_tod` is 1, arms it on the next edge. `cmd_rdata` then reads 0x1000_0000 (bit 28 = armed, bits 30 and 29 = 0).
- R4: While armed, on the first edge where `tod >= start time`, the controller enters running. `engine_start` is high for exactly that one cycle, `engine_run` stays high from then on, and `cmd_rdata` reads 0x4000_0000 (bit 30 = running).
- R5: While armed and `tod` is below the start time, compared as full 64-bit unsigned values, the controller stays armed and raises no `engine_start`.
- R6: A valid write with stop = 1 moves the controller to disabled on the next edge, from armed or from running. `engine_run` drops and `cmd_rdata` reads 0x2000_0000.
- R7: When start and stop are both 1 in one valid write, stop wins. Nothing is armed and no error is raised.
- R8: A valid start request (stop = 0) made while armed or running does not change the state. It raises `cmd_err` for exactly one cycle, and an armed controller still fires on time.
- R9: The start time is written 32 bits at a time. `st_wr` with `st_sel` = 0 loads bits 31:0 and `st_sel` = 1 loads bits 63:32. The other word holds its value, and `st_rdata` shows the full 64-bit value on the edge after the write.
- R10: With `use_tod` = 0, `cmd_rdata` bits 30 and 29 both read 0. A start request made while disabled is refused with a one-cycle `cmd_err`, and the controller stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_tod | input | 1 | 1 = schedule is driven from the time-of-day source |
| tod | input | 64 | Free-running time-of-day counter |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: bit 31 valid, bit 30 start, bit 29 stop |
| cmd_rdata | output | 32 | Status: bit 30 running, bit 29 stopped, bit 28 armed |
| st_wr | input | 1 | Start time word write strobe |
| st_sel | input | 1 | Start time word select, 0 = low word, 1 = high word |
| st_wdata | input | 32 | Start time word data |
| st_rdata | output | 64 | Current start time |
| engine_start | output | 1 | One-cycle pulse when the schedule engine is released |
| engine_run | output | 1 | Schedule engine enable |
| cmd_err | output | 1 | One-cycle pulse for a refused start request |

## Verification
On every cycle, the assertions check the following:
- the release pulse lasts one cycle, comes only out of the armed state and is joined by the run enable;
- the pulse is never raised while the comparator reports that the time is still short;
- a decoded stop always lands in disabled;
- a busy start always yields an error pulse;
- an idle start-time word holds its value.

Only the bench scenarios can show the rest:
- the exact status codes;
- the fire boundary at one tick before and at the start time, including a high-word difference;
- the two-word load order;
- that invalid writes and refused starts leave the visible state as it was.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {
    SGC_DISABLED = 2'd0,
    SGC_ARMED    = 2'd1,
    SGC_RUNNING  = 2'd2
  } sgc_state_e;

  localparam int unsigned CMD_W       = 32;
  localparam int unsigned BIT_VALID   = CMD_W - 1;
  localparam int unsigned BIT_START   = CMD_W - 2;
  localparam int unsigned BIT_STOP    = CMD_W - 3;
  localparam int unsigned BIT_ARMED   = CMD_W - 4;
endpackage

// File: rtl/sgc_cmd_decode.sv
module sgc_cmd_decode
  import sgc_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic             start_req,
  output logic             stop_req
);
  logic accepted;

  always_comb begin
    accepted  = cmd_wr && cmd_wdata[BIT_VALID];
    // stop has priority over start when both are set
    stop_req  = accepted && cmd_wdata[BIT_STOP];
    start_req = accepted && cmd_wdata[BIT_START] && !cmd_wdata[BIT_STOP];
  end
endmodule

// File: rtl/sgc_time_reg.sv
module sgc_time_reg #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NWORDS = TIME_W / WORD_W,
  localparam int unsigned SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [TIME_W-1:0] value
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        value[w*WORD_W +: WORD_W] <= '0;
      end else if (wr && (sel == SEL_W'(w))) begin
        value[w*WORD_W +: WORD_W] <= wdata;
      end
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (sel == SEL_W'(w))) |=> $stable(value[w*WORD_W +: WORD_W])); // R9
  end
endmodule

// File: rtl/sgc_time_cmp.sv
module sgc_time_cmp #(
  parameter int unsigned TIME_W = 64
) (
  input  logic [TIME_W-1:0] tod,
  input  logic [TIME_W-1:0] start_time,
  output logic              reached
);
  always_comb reached = (tod >= start_time);
endmodule

// File: rtl/sgc_fsm.sv
module sgc_fsm
  import sgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_tod,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       reached,
  output sgc_state_e state,
  output logic       start_pulse,
  output logic       err_pulse
);
  logic can_arm;
  logic fire;

  always_comb begin
    can_arm = (state == SGC_DISABLED) && use_tod;
    fire    = (state == SGC_ARMED) && reached && !stop_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SGC_DISABLED;
      start_pulse <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      start_pulse <= fire;
      err_pulse   <= start_req && !can_arm;
      if (stop_req) begin
        state <= SGC_DISABLED;
      end else if (start_req && can_arm) begin
        state <= SGC_ARMED;
      end else if (fire) begin
        state <= SGC_RUNNING;
      end
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R4
  AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> $past(state) == SGC_ARMED); // R4
  AST_START_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> state == SGC_RUNNING); // R4
  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SGC_ARMED && !reached) |=> !start_pulse); // R5
  AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> state == SGC_DISABLED); // R6
  AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && state != SGC_DISABLED) |=> err_pulse); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(start_req)) |-> 1'b0); // R8
endmodule

// File: rtl/sgc_gate_ctrl.sv
module sgc_gate_ctrl
  import sgc_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_tod,
  input  logic [TIME_W-1:0] tod,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  input  logic              st_wr,
  input  logic              st_sel,
  input  logic [WORD_W-1:0] st_wdata,
  output logic [TIME_W-1:0] st_rdata,
  output logic              engine_start,
  output logic              engine_run,
  output logic              cmd_err
);
  logic       start_req;
  logic       stop_req;
  logic       reached;
  sgc_state_e state;

  sgc_cmd_decode u_dec (
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .start_req (start_req),
    .stop_req  (stop_req)
  );

  sgc_time_reg #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_treg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (st_wr),
    .sel   (st_sel),
    .wdata (st_wdata),
    .value (st_rdata)
  );

  sgc_time_cmp #(.TIME_W(TIME_W)) u_cmp (
    .tod        (tod),
    .start_time (st_rdata),
    .reached    (reached)
  );

  sgc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_tod     (use_tod),
    .start_req   (start_req),
    .stop_req    (stop_req),
    .reached     (reached),
    .state       (state),
    .start_pulse (engine_start),
    .err_pulse   (cmd_err)
  );

  always_comb begin
    engine_run           = (state == SGC_RUNNING);
    cmd_rdata            = '0;
    cmd_rdata[BIT_START] = use_tod && (state == SGC_RUNNING);
    cmd_rdata[BIT_STOP]  = use_tod && (state == SGC_DISABLED);
    cmd_rdata[BIT_ARMED] = (state == SGC_ARMED);
  end

  AST_RUN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engine_run) |-> engine_start); // R4
endmodule

// File: tb/test_sgc_gate_ctrl.sv
module test_sgc_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        use_tod;
  logic [63:0] tod;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic        st_wr;
  logic        st_sel;
  logic [31:0] st_wdata;
  logic [63:0] st_rdata;
  logic        engine_start;
  logic        engine_run;
  logic        cmd_err;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] C_START = 32'hC000_0000;
  localparam logic [31:0] C_STOP  = 32'hA000_0000;
  localparam logic [31:0] C_BOTH  = 32'hE000_0000;
  localparam logic [31:0] S_STOP  = 32'h2000_0000;
  localparam logic [31:0] S_ARMED = 32'h1000_0000;
  localparam logic [31:0] S_RUN   = 32'h4000_0000;

  always #2 clk = ~clk;

  sgc_gate_ctrl i_sgc_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .use_tod(use_tod), .tod(tod),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .st_wr(st_wr), .st_sel(st_sel), .st_wdata(st_wdata), .st_rdata(st_rdata),
    .engine_start(engine_start), .engine_run(engine_run), .cmd_err(cmd_err)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(logic [31:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    step();
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic load_st(logic [63:0] t);
    st_wr = 1'b1; st_sel = 1'b0; st_wdata = t[31:0];
    step();
    st_sel = 1'b1; st_wdata = t[63:32];
    step();
    st_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; use_tod = 1'b1; tod = '0; cmd_wr = 1'b0; cmd_wdata = '0;
    st_wr = 1'b0; st_sel = 1'b0; st_wdata = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status", cmd_rdata, S_STOP);
    check("R1 run", engine_run, 0);
    check("R1 start", engine_start, 0);
    check("R1 err", cmd_err, 0);
  endtask

  task automatic t_valid_gate();
    cmd(32'h4000_0000);
    check("R2 no-valid status", cmd_rdata, S_STOP);
    check("R2 no-valid err", cmd_err, 0);
  endtask

  task automatic t_words();
    st_wr = 1'b1; st_sel = 1'b0; st_wdata = 32'hDEAD_BEEF;
    step();
    check("R9 low word", st_rdata, 64'h0000_0000_DEAD_BEEF);
    st_sel = 1'b1; st_wdata = 32'h0123_4567;
    step();
    st_wr = 1'b0;
    check("R9 both words", st_rdata, 64'h0123_4567_DEAD_BEEF);
    step();
    check("R9 hold", st_rdata, 64'h0123_4567_DEAD_BEEF);
  endtask

  task automatic t_arm_fire();
    load_st(64'd100);
    tod = 64'd99;
    cmd(C_START);
    check("R3 armed status", cmd_rdata, S_ARMED);
    check("R3 not running", engine_run, 0);
    step();
    check("R5 below start no pulse", engine_start, 0);
    check("R5 still armed", cmd_rdata, S_ARMED);
    tod = 64'd100;
    step();
    check("R4 pulse", engine_start, 1);
    check("R4 run", engine_run, 1);
    check("R4 status", cmd_rdata, S_RUN);
    tod = 64'd101;
    step();
    check("R4 pulse one cycle", engine_start, 0);
    check("R4 run held", engine_run, 1);
  endtask

  task automatic t_busy_start();
    cmd(C_START);
    check("R8 err running", cmd_err, 1);
    check("R8 state running", cmd_rdata, S_RUN);
    step();
    check("R8 err one cycle", cmd_err, 0);
  endtask

  task automatic t_stop_running();
    cmd(C_STOP);
    check("R6 stop running status", cmd_rdata, S_STOP);
    check("R6 run dropped", engine_run, 0);
  endtask

  task automatic t_high_word();
    load_st(64'h0000_0001_0000_0000);
    tod = 64'h0000_0000_FFFF_FFFF;
    cmd(C_START);
    step();
    check("R5 high word no pulse", engine_start, 0);
    check("R5 high word armed", cmd_rdata, S_ARMED);
    cmd(C_START);
    check("R8 err armed", cmd_err, 1);
    check("R8 still armed", cmd_rdata, S_ARMED);
    tod = 64'h0000_0001_0000_0000;
    step();
    check("R8 armed fires after busy start", engine_start, 1);
    cmd(C_STOP);
  endtask

  task automatic t_stop_armed();
    load_st(64'd1000);
    tod = 64'd10;
    cmd(C_START);
    check("R6 armed first", cmd_rdata, S_ARMED);
    cmd(C_STOP);
    check("R6 stop armed status", cmd_rdata, S_STOP);
    tod = 64'd2000;
    step();
    check("R6 no fire after stop", engine_start, 0);
  endtask

  task automatic t_both();
    tod = 64'd2000;
    cmd(C_BOTH);
    check("R7 both stop wins", cmd_rdata, S_STOP);
    check("R7 no err", cmd_err, 0);
    step();
    check("R7 no fire", engine_start, 0);
  endtask

  task automatic t_no_tod();
    use_tod = 1'b0;
    step();
    check("R10 status none", cmd_rdata, 32'h0);
    cmd(C_START);
    check("R10 err", cmd_err, 1);
    use_tod = 1'b1;
    step();
    check("R10 stayed disabled", cmd_rdata, S_STOP);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_valid_gate();
        t_words();
        t_arm_fire();
        t_busy_start();
        t_stop_running();
        t_high_word();
        t_stop_armed();
        t_both();
        t_no_tod();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule